// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the timing and control unit of a small single-accumulator computer. A step counter walks each instruction through address setup, instruction fetch, decode, an optional indirect-address lookup and the execute steps of the memory-reference instructions. The block owns the program counter, address register, instruction register, operand register, accumulator and carry flag. It talks to an external word memory that has a synchronous read port: data requested in one cycle is on `mem_rdata` in the next.

A 16-bit instruction word is laid out as follows. Bit 15 is the indirect flag. Bits 14:12 hold the opcode. Bits 11:0 hold a word address. Opcodes 0 to 4 are executed here: logical AND with a memory word, add with carry-out, load, store and unconditional jump. Opcodes 5 and 6 are accepted and retired with no effect. Opcode 7 is not executed here. It is handed to a neighbouring register/IO unit through a one-cycle dispatch strobe that carries the indirect bit and the 12-bit code field.

The sequencer idles until `start` is seen. It keeps running until a halt word is dispatched.

Top module: `acc_seq_ctrl`

## Requirements
- R1: After reset the program counter, accumulator, carry flag, run flag and step counter are all 0.
- R2: While the run flag is 0, the step counter holds 0 and no memory read, write or dispatch occurs. A cycle with `start` high sets the run flag, and step 0 begins on the following cycle.
- R3: At step 0 the address register takes the program counter. At step 1 a read is issued at that address and the program counter increments by one, modulo 4096.
- R4: The step counter follows 0,1,2,3 and then goes on by opcode. Opcode 7 returns to 0 after step 3. A direct instruction jumps from step 3 to step 5, and an indirect one passes through step 4. STA, BUN and opcodes 5 and 6 return to 0 after step 5. AND, ADD and LDA continue through steps 6 and 7 and then return to 0. The counter never exceeds 7.
- R5: For opcodes 0 to 6 with bit 15 set, step 3 issues a read at the address field, and bits 11:0 of the word returned become the effective address.
- R6: AND (opcode 0) replaces the accumulator with its bitwise AND with the word at the effective address. The accumulator changes only at step 7.
- R7: ADD (opcode 1) replaces the accumulator with the low 16 bits of the sum and places the carry-out in the carry flag. No other instruction changes the carry flag.
- R8: LDA (opcode 2) copies the word at the effective address into the accumulator.
- R9: STA (opcode 3) asserts a write for exactly the step-5 cycle, with the effective address and the accumulator value. A read never occurs in the same cycle.
- R10: BUN (opcode 4) loads the program counter with the effective address at step 5.
- R11: Opcode 7 raises `grp_go` for the single step-3 cycle, with `grp_io` equal to bit 15 and `grp_code` equal to bits 11:0. No indirect read is made for it.
- R12: An opcode-7 word with bit 15 clear and code bit 0 set is a halt. It clears the run flag, and the step counter is 0 afterwards.
- R13: Opcodes 5 and 6 change neither the accumulator, the carry flag nor memory. They only advance the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sets the run flag when idle |
| mem_addr | output | 12 | Memory word address (the address register) |
| mem_rd | output | 1 | Read request; data is expected on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| grp_go | output | 1 | One-cycle dispatch strobe for opcode 7 |
| grp_io | output | 1 | Indirect bit of the dispatched word |
| grp_code | output | 12 | Code field of the dispatched word |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag |
| run_o | output | 1 | Run flag |
| step_o | output | 4 | Step counter |

## Verification
The program mixes direct and indirect forms of every memory-reference opcode, so a sequencer that skipped step 4 or read the wrong effective address would load stale data or store to the wrong word. An ADD that overflows is followed later by an ADD that does not, which exposes a carry flag that is never cleared or is written by other opcodes. Indirect forms of opcodes 5 and 6 are included, as is a non-halt dispatch word with the indirect bit set. These catch a design that treats opcode 7 as memory-reference or decodes the halt from the wrong bit. The program halts, idles and is restarted, which exposes a machine that keeps stepping while stopped or loses the program counter across the restart.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OPC_AND  = 3'd0,
      OPC_ADD  = 3'd1,
      OPC_LDA  = 3'd2,
      OPC_STA  = 3'd3,
      OPC_BUN  = 3'd4,
      OPC_RSV5 = 3'd5,
      OPC_RSV6 = 3'd6,
      OPC_GRP  = 3'd7
   } opc_e;

   typedef struct packed {
      logic use_operand;
      logic do_and;
      logic do_add;
      logic do_lda;
      logic do_sta;
      logic do_bun;
      logic do_grp;
   } opc_cls_t;

   // step numbers; the order is the sequence of an instruction
   localparam int ST_ADDR  = 0;
   localparam int ST_FETCH = 1;
   localparam int ST_DEC   = 2;
   localparam int ST_DISP  = 3;
   localparam int ST_INDIR = 4;
   localparam int ST_EXEC  = 5;
   localparam int ST_OPND  = 6;
   localparam int ST_APPLY = 7;
endpackage

// File: rtl/acc_step_ctr.sv
module acc_step_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         jump,
   input  logic [W-1:0] jump_to,
   input  logic         adv,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   if (W < 3) begin : g_bad_w
      $error("acc_step_ctr: W must be at least 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (jump)  cnt <= jump_to;
      else if (adv)   cnt <= cnt + ONE;
   end
endmodule

// File: rtl/acc_op_decode.sv
module acc_op_decode
   import acc_seq_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output opc_cls_t         cls
);
   always_comb begin
      cls = '0;
      case (opc)
         OPC_AND: begin cls.do_and = 1'b1; cls.use_operand = 1'b1; end
         OPC_ADD: begin cls.do_add = 1'b1; cls.use_operand = 1'b1; end
         OPC_LDA: begin cls.do_lda = 1'b1; cls.use_operand = 1'b1; end
         OPC_STA: cls.do_sta = 1'b1;
         OPC_BUN: cls.do_bun = 1'b1;
         OPC_GRP: cls.do_grp = 1'b1;
         default: cls = '0;
      endcase
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
   parameter int W         = 16,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic         do_and,
   input  logic         do_add,
   input  logic         do_lda,
   input  logic [W-1:0] acc,
   input  logic [W-1:0] opnd,
   input  logic         e_in,
   output logic [W-1:0] res,
   output logic         e_out
);
   logic [W:0] sum;

   if (W < 2) begin : g_bad_w
      $error("acc_alu: W must be at least 2");
   end

   if (SPLIT_ADD) begin : g_split
      localparam int LO = W / 2;
      localparam int HI = W - LO;
      logic [LO:0] lo_s;
      logic [HI:0] hi_s;
      assign lo_s = {1'b0, acc[LO-1:0]} + {1'b0, opnd[LO-1:0]};
      assign hi_s = {1'b0, acc[W-1:LO]} + {1'b0, opnd[W-1:LO]} + {{HI{1'b0}}, lo_s[LO]};
      assign sum  = {hi_s, lo_s[LO-1:0]};
   end else begin : g_flat
      assign sum = {1'b0, acc} + {1'b0, opnd};
   end

   always_comb begin
      res   = acc;
      e_out = e_in;
      if (do_and)      res = acc & opnd;
      else if (do_add) {e_out, res} = sum;
      else if (do_lda) res = opnd;
   end
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
   import acc_seq_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int STEP_W    = 4,
   parameter bit SPLIT_ADD = 1'b0,
   parameter int HALT_BIT  = 0,
   localparam int WORD_W   = 1 + OPC_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              grp_go,
   output logic              grp_io,
   output logic [ADDR_W-1:0] grp_code,
   output logic [ADDR_W-1:0] pc_o,
   output logic [WORD_W-1:0] ac_o,
   output logic              e_o,
   output logic              run_o,
   output logic [STEP_W-1:0] step_o
);
   localparam logic [STEP_W-1:0] S_ADDR  = STEP_W'(ST_ADDR);
   localparam logic [STEP_W-1:0] S_FETCH = STEP_W'(ST_FETCH);
   localparam logic [STEP_W-1:0] S_DEC   = STEP_W'(ST_DEC);
   localparam logic [STEP_W-1:0] S_DISP  = STEP_W'(ST_DISP);
   localparam logic [STEP_W-1:0] S_INDIR = STEP_W'(ST_INDIR);
   localparam logic [STEP_W-1:0] S_EXEC  = STEP_W'(ST_EXEC);
   localparam logic [STEP_W-1:0] S_OPND  = STEP_W'(ST_OPND);
   localparam logic [STEP_W-1:0] S_APPLY = STEP_W'(ST_APPLY);
   localparam logic [ADDR_W-1:0] PC_ONE  = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam int IND_BIT = WORD_W - 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("acc_seq_ctrl: ADDR_W must be at least 2");
   end
   if (STEP_W < 3) begin : g_bad_step
      $error("acc_seq_ctrl: STEP_W must be at least 3");
   end
   if (HALT_BIT < 0 || HALT_BIT >= ADDR_W) begin : g_bad_halt
      $error("acc_seq_ctrl: HALT_BIT out of range");
   end

   logic [ADDR_W-1:0] pc_q, ar_q;
   logic [WORD_W-1:0] ir_q, dr_q, ac_q;
   logic              e_q, i_q, run_q;
   logic [STEP_W-1:0] step;
   opc_cls_t          cls;
   logic [WORD_W-1:0] alu_res;
   logic              alu_e;
   logic              ctr_clr, ctr_jump, ctr_adv;
   logic              halt_now;

   acc_step_ctr #(.W(STEP_W)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctr_clr),
      .jump    (ctr_jump),
      .jump_to (S_EXEC),
      .adv     (ctr_adv),
      .cnt     (step)
   );

   acc_op_decode u_dec (
      .opc (ir_q[WORD_W-2 -: OPC_W]),
      .cls (cls)
   );

   acc_alu #(.W(WORD_W), .SPLIT_ADD(SPLIT_ADD)) u_alu (
      .do_and (cls.do_and),
      .do_add (cls.do_add),
      .do_lda (cls.do_lda),
      .acc    (ac_q),
      .opnd   (dr_q),
      .e_in   (e_q),
      .res    (alu_res),
      .e_out  (alu_e)
   );

   // step sequencing
   always_comb begin
      ctr_clr  = 1'b0;
      ctr_jump = 1'b0;
      ctr_adv  = 1'b0;
      if (run_q) begin
         case (step)
            S_DISP: begin
               if (cls.do_grp)  ctr_clr  = 1'b1;
               else if (i_q)    ctr_adv  = 1'b1;
               else             ctr_jump = 1'b1;
            end
            S_EXEC: begin
               if (cls.use_operand) ctr_adv = 1'b1;
               else                 ctr_clr = 1'b1;
            end
            S_APPLY: ctr_clr = 1'b1;
            default: begin
               if (step > S_APPLY) ctr_clr = 1'b1;
               else                ctr_adv = 1'b1;
            end
         endcase
      end
   end

   // memory and dispatch strobes
   always_comb begin
      mem_rd = 1'b0;
      if (run_q) begin
         if (step == S_FETCH)                          mem_rd = 1'b1;
         else if (step == S_DISP && !cls.do_grp && i_q) mem_rd = 1'b1;
         else if (step == S_EXEC && cls.use_operand)   mem_rd = 1'b1;
      end
   end

   assign mem_wr    = run_q && (step == S_EXEC) && cls.do_sta;
   assign mem_addr  = ar_q;
   assign mem_wdata = ac_q;
   assign grp_go    = run_q && (step == S_DISP) && cls.do_grp;
   assign grp_io    = i_q;
   assign grp_code  = ar_q;
   assign halt_now  = grp_go && !i_q && ar_q[HALT_BIT];

   // run flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_q <= 1'b0;
      else if (!run_q)      run_q <= start;
      else if (halt_now)    run_q <= 1'b0;
   end

   // register transfers per step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
         ar_q <= '0;
         ir_q <= '0;
         dr_q <= '0;
         ac_q <= '0;
         e_q  <= 1'b0;
         i_q  <= 1'b0;
      end else if (run_q) begin
         case (step)
            S_ADDR:  ar_q <= pc_q;
            S_FETCH: pc_q <= pc_q + PC_ONE;
            S_DEC: begin
               ir_q <= mem_rdata;
               i_q  <= mem_rdata[IND_BIT];
               ar_q <= mem_rdata[ADDR_W-1:0];
            end
            S_INDIR: ar_q <= mem_rdata[ADDR_W-1:0];
            S_EXEC:  if (cls.do_bun) pc_q <= ar_q;
            S_OPND:  dr_q <= mem_rdata;
            S_APPLY: begin
               ac_q <= alu_res;
               e_q  <= alu_e;
            end
            default: ;
         endcase
      end
   end

   assign pc_o   = pc_q;
   assign ac_o   = ac_q;
   assign e_o    = e_q;
   assign run_o  = run_q;
   assign step_o = step;
endmodule

module acc_seq_ctrl_chk #(
   parameter int ADDR_W = 12,
   parameter int STEP_W = 4,
   localparam int WORD_W = 4 + ADDR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              grp_go,
   input logic [ADDR_W-1:0] pc_o,
   input logic [WORD_W-1:0] ac_o,
   input logic              e_o,
   input logic              run_o,
   input logic [STEP_W-1:0] step_o
);
   localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
   localparam logic [STEP_W-1:0] S5 = STEP_W'(5);
   localparam logic [STEP_W-1:0] S7 = STEP_W'(7);

   p_idle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_o |-> step_o == '0);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_o |-> (!mem_rd && !mem_wr && !grp_go));
   p_pc_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && step_o == S1) |=> pc_o == ADDR_W'($past(pc_o) + 1));
   p_step_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step_o <= S7);
   p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && step_o == S7) |=> step_o == '0);
   p_ac_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_o && step_o == S7) |=> $stable(ac_o));
   p_e_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_o && step_o == S7) |=> $stable(e_o));
   p_wr_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (!mem_rd && step_o == S5));
   p_grp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      grp_go |=> !grp_go);
   p_halt_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_o) |-> step_o == '0);
endmodule

bind acc_seq_ctrl acc_seq_ctrl_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mem_rd (mem_rd),
   .mem_wr (mem_wr),
   .grp_go (grp_go),
   .pc_o   (pc_o),
   .ac_o   (ac_o),
   .e_o    (e_o),
   .run_o  (run_o),
   .step_o (step_o)
);

// File: tb/sim_acc_seq_ctrl.sv
module sim_acc_seq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] rdata = '0;
   logic        grp_go, grp_io;
   logic [11:0] grp_code, pc_o;
   logic [15:0] ac_o;
   logic        e_o, run_o;
   logic [3:0]  step_o;

   always #2.5 clk = ~clk;

   acc_seq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(rdata),
      .grp_go(grp_go), .grp_io(grp_io), .grp_code(grp_code),
      .pc_o(pc_o), .ac_o(ac_o), .e_o(e_o), .run_o(run_o), .step_o(step_o)
   );

   logic [15:0] mem [0:4095];
   int total = 0;
   int bad = 0;
   int cyc = 0;
   int halts = 0;
   int go_seen = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   // reference machine state
   int          m_t;
   logic [11:0] m_pc, m_ar;
   logic [15:0] m_ir, m_ac, m_dr;
   logic        m_e, m_run, m_i;
   logic [2:0]  m_op;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at cycle %0d: got %h expected %h", what, cyc, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // memory model and reference machine advance together
   always @(posedge clk) begin
      cyc++;
      if (mem_rd) rdata <= mem[mem_addr];
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (!rst_n) begin
         m_t = 0; m_pc = '0; m_ar = '0; m_ir = '0; m_ac = '0; m_dr = '0;
         m_e = 1'b0; m_run = 1'b0; m_i = 1'b0; m_op = '0;
      end else if (!m_run) begin
         if (start) m_run = 1'b1;
      end else begin
         case (m_t)
            0: begin m_ar = m_pc; m_t = 1; end
            1: begin m_ir = mem[m_ar]; m_pc = m_pc + 12'd1; m_t = 2; end
            2: begin m_i = m_ir[15]; m_op = m_ir[14:12]; m_ar = m_ir[11:0]; m_t = 3; end
            3: begin
               if (m_op == 3'd7) begin
                  if (!m_i && m_ar[0]) begin m_run = 1'b0; halts++; end
                  m_t = 0;
               end else if (m_i) begin
                  m_ar = mem[m_ar][11:0]; m_t = 4;
               end else m_t = 5;
            end
            4: m_t = 5;
            5: begin
               if (m_op <= 3'd2) begin m_dr = mem[m_ar]; m_t = 6; end
               else begin
                  if (m_op == 3'd4) m_pc = m_ar;
                  m_t = 0;
               end
            end
            6: m_t = 7;
            default: begin
               case (m_op)
                  3'd0: m_ac = m_ac & m_dr;
                  3'd1: {m_e, m_ac} = {1'b0, m_ac} + {1'b0, m_dr};
                  3'd2: m_ac = m_dr;
                  default: ;
               endcase
               m_t = 0;
            end
         endcase
      end
      if (cyc > 20000 && !done) begin
         bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         finish_run();
      end
   end

   // compare with the reference on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         bit e_rd, e_wr, e_go;
         e_rd = m_run && (m_t == 1 || (m_t == 3 && m_op != 3'd7 && m_i) || (m_t == 5 && m_op <= 3'd2));
         e_wr = m_run && m_t == 5 && m_op == 3'd3;
         e_go = m_run && m_t == 3 && m_op == 3'd7;
         chk(step_o == 4'(m_t), "R4 step", 32'(step_o), 32'(m_t));
         chk(pc_o == m_pc, "R3 R10 pc", 32'(pc_o), 32'(m_pc));
         chk(ac_o == m_ac, "R6 R8 R13 ac", 32'(ac_o), 32'(m_ac));
         chk(e_o == m_e, "R7 carry", 32'(e_o), 32'(m_e));
         chk(run_o == m_run, "R2 R12 run", 32'(run_o), 32'(m_run));
         chk(mem_rd == e_rd, "R3 R5 rd", 32'(mem_rd), 32'(e_rd));
         chk(mem_wr == e_wr, "R9 R13 wr", 32'(mem_wr), 32'(e_wr));
         chk(grp_go == e_go, "R11 go", 32'(grp_go), 32'(e_go));
         if (e_rd || e_wr) chk(mem_addr == m_ar, "R5 R9 addr", 32'(mem_addr), 32'(m_ar));
         if (e_wr) chk(mem_wdata == m_ac, "R9 wdata", 32'(mem_wdata), 32'(m_ac));
         if (e_go) begin
            chk(grp_io == m_i, "R11 io", 32'(grp_io), 32'(m_i));
            chk(grp_code == m_ar, "R11 code", 32'(grp_code), 32'(m_ar));
         end
         if (grp_go) go_seen++;
      end
   end

   function automatic logic [15:0] enc(input bit ind, input int op, input int a);
      return {ind, 3'(op), 12'(a)};
   endfunction

   initial begin
      for (int k = 0; k < 4096; k++) mem[k] = '0;
      mem[12'h100] = 16'h00F0;
      mem[12'h101] = 16'h0F3C;
      mem[12'h102] = 16'h8001;
      mem[12'h103] = 16'hFFFF;
      mem[12'h104] = 16'h0105;
      mem[12'h105] = 16'h1234;
      mem[12'h106] = 16'h0107;
      mem[12'h109] = 16'h0030;
      mem[0]  = enc(0, 2, 'h101);   // LDA
      mem[1]  = enc(0, 0, 'h100);   // AND
      mem[2]  = enc(0, 1, 'h101);   // ADD, no carry
      mem[3]  = enc(0, 2, 'h102);
      mem[4]  = enc(0, 1, 'h103);   // ADD with carry out
      mem[5]  = enc(1, 2, 'h104);   // LDA indirect
      mem[6]  = enc(0, 3, 'h108);   // STA
      mem[7]  = enc(1, 3, 'h106);   // STA indirect
      mem[8]  = enc(0, 5, 'h100);   // reserved opcode
      mem[9]  = enc(1, 6, 'h104);   // reserved opcode, indirect
      mem[10] = enc(1, 7, 'h0A5);   // dispatch with io bit
      mem[11] = enc(0, 4, 'h020);   // BUN
      mem[12'h020] = enc(1, 4, 'h109);  // BUN indirect
      mem[12'h030] = enc(0, 7, 'h004);  // dispatch, not a halt
      mem[12'h031] = enc(0, 1, 'h100);  // ADD clears carry
      mem[12'h032] = enc(0, 7, 'h001);  // halt
      mem[12'h033] = enc(0, 0, 'h000);  // AND after restart
      mem[12'h034] = enc(0, 7, 'h001);  // halt

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pc_o == 12'h000, "R1 pc", 32'(pc_o), 32'h0);
      chk(ac_o == 16'h0000, "R1 ac", 32'(ac_o), 32'h0);
      chk(e_o == 1'b0, "R1 carry", 32'(e_o), 32'h0);
      chk(run_o == 1'b0, "R1 run", 32'(run_o), 32'h0);
      chk(step_o == 4'd0, "R1 step", 32'(step_o), 32'h0);
      cmp_en = 1'b1;
      repeat (4) @(negedge clk);
      chk(!mem_rd && step_o == 4'd0, "R2 idle", 32'({mem_rd, step_o}), 32'h0);

      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (halts < 1) @(negedge clk);
      @(negedge clk);
      // R9 store targets, R5 indirect store
      chk(mem[12'h108] == 16'h1234, "R9 store", 32'(mem[12'h108]), 32'h1234);
      chk(mem[12'h107] == 16'h1234, "R5 indirect store", 32'(mem[12'h107]), 32'h1234);
      chk(ac_o == 16'h1324 && e_o == 1'b0, "R7 carry cleared", 32'({e_o, ac_o}), 32'h1324);
      chk(pc_o == 12'h033, "R10 R12 pc after halt", 32'(pc_o), 32'h033);
      repeat (6) @(negedge clk);
      chk(!run_o && step_o == 4'd0, "R12 stays halted", 32'({run_o, step_o}), 32'h0);

      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (halts < 2) @(negedge clk);
      @(negedge clk);
      chk(ac_o == 16'h0100, "R6 and after restart", 32'(ac_o), 32'h0100);
      chk(pc_o == 12'h035, "R3 pc after restart", 32'(pc_o), 32'h035);
      chk(go_seen == 4, "R11 dispatch count", 32'(go_seen), 32'd4);
      chk(mem[12'h100] == 16'h00F0 && mem[12'h104] == 16'h0105, "R13 memory untouched",
          32'({mem[12'h100], mem[12'h104]}), 32'h00F00105);
      finish_run();
   end
endmodule